// File: doc/BRIEF.md
# Watchdog Reset Gate with Cause Latch

This block sits on the power-management side, between a watchdog timer and the system reset controller. It decides whether a reset request from the watchdog may turn into a system reset. It stretches an accepted request into a fixed-length reset pulse. It also drives the enable that the watchdog counter needs before it can count. A sticky cause flag records that the last system reset came from the watchdog. That flag sits on its own power-on reset, so it survives the system reset that it reports.

Software uses a four-entry register port with a combinational read. Each control register keeps one bit, at a position set by a parameter; every other bit reads as zero. A polarity parameter sets the meaning of the mask bit. With `MASK_POL=1`, a set bit blocks watchdog resets. With `MASK_POL=0`, a set bit lets them through. A separate auto-disable bit drops watchdog requests while the associated processor is held in reset.

Top module: `wdt_rst_gate`

## Requirements
- R1: After `rst` and `por_rst`, `sys_rst_o` and `cnt_en_o` are 0. The mask register (address 0) reads its blocking value: bit MASK_BIT (default 20) is set when MASK_POL=1 and clear when MASK_POL=0. The auto-disable register (address 1) reads 1 at bit AUTO_BIT (default 20). The counter-enable register (address 2) and the status register (address 3) read 0.
- R2: When MASK_POL=1, a set mask bit blocks watchdog requests and a clear bit passes them. When MASK_POL=0, a clear bit blocks and a set bit passes.
- R3: While the auto-disable bit is 1 and `cpu_in_rst_i` is 1, a watchdog request produces no pulse. With the auto-disable bit at 0, `cpu_in_rst_i` has no effect.
- R4: `cnt_en_o` equals the stored counter-enable bit (bit CNT_BIT, default 7, of address 2). It takes the written value on the edge that performs the write.
- R5: An accepted request, sampled at edge k, raises `sys_rst_o` after edge k. The pulse lasts exactly PULSE_LEN cycles (default 4, never below 4).
- R6: A request held high yields a single pulse. A new pulse needs the request to go low and then high again.
- R7: The cause flag is set on the edge that starts a pulse. It reads as bit CAUSE_BIT (default 9) of address 3. A blocked request leaves it at 0.
- R8: The cause flag is unaffected by `rst` and by writing 0. It is cleared by writing 1 at bit CAUSE_BIT of address 3, or by `por_rst`.
- R9: Writes change only the configured bit of each control register. All other read bits are 0.
- R10: If a pulse starts on the same edge as a write-1 clear of the cause flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset for the control registers and the pulse logic |
| por_rst | input | 1 | Synchronous active-high power-on reset for the cause flag only |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 mask, 1 auto-disable, 2 counter enable, 3 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| wdt_req_i | input | 1 | Reset request from the watchdog |
| cpu_in_rst_i | input | 1 | Associated processor is held in reset |
| sys_rst_o | output | 1 | Reset pulse to the system reset controller |
| cnt_en_o | output | 1 | Enable for the watchdog counter |

## Verification
Register writes and the counter enable take effect one edge after the strobe is sampled. The bench reads them back at the following falling edge through the combinational read path. `sys_rst_o` and the cause flag both change on the edge after a qualifying request is sampled. The bench therefore samples them at the next falling edge, then counts high samples over PULSE_LEN+3 falling edges to check the pulse length. The checks on blocking, retriggering and flag persistence look at the outputs and the status read after the edge where a change would have shown.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
    localparam int WRG_DW = 32;
    localparam int WRG_AW = 2;

    typedef enum logic [WRG_AW-1:0] {
        SEL_MASK  = 2'd0,
        SEL_AUTO  = 2'd1,
        SEL_CNTEN = 2'd2,
        SEL_STAT  = 2'd3
    } sel_e;

    typedef struct packed {
        logic mask;
        logic auto_dis;
        logic cnt_en;
    } ctrl_t;

    typedef struct packed {
        logic req;
        logic cpu_rst;
    } gate_in_t;

    function automatic logic [WRG_DW-1:0] place_bit(input logic v, input int unsigned pos);
        logic [WRG_DW-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

    // allow = 1 when the stored mask bit lets watchdog resets pass
    function automatic logic mask_allows(input logic m, input logic pol_blocks_when_set);
        return pol_blocks_when_set ? ~m : m;
    endfunction
endpackage

// File: rtl/wrg_regs.sv
module wrg_regs
    import wrg_pkg::*;
#(
    parameter bit MASK_POL = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  sel_e  sel,
    input  ctrl_t wr_bits,
    output ctrl_t ctrl_q
);
    ctrl_t rst_val;

    generate
        if (MASK_POL) begin : g_pol_high
            assign rst_val = '{mask: 1'b1, auto_dis: 1'b1, cnt_en: 1'b0};
        end else begin : g_pol_low
            assign rst_val = '{mask: 1'b0, auto_dis: 1'b1, cnt_en: 1'b0};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= rst_val;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK:  ctrl_q.mask     <= wr_bits.mask;
                SEL_AUTO:  ctrl_q.auto_dis <= wr_bits.auto_dis;
                SEL_CNTEN: ctrl_q.cnt_en   <= wr_bits.cnt_en;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/wrg_gate.sv
module wrg_gate
    import wrg_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4,
    parameter bit          MASK_POL  = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  gate_in_t gin,
    input  ctrl_t    ctrl,
    output logic     sys_rst,
    output logic     start
);
    localparam int unsigned CW = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

    logic          armed_q;
    logic [CW-1:0] left_q;
    logic          pass;
    logic          qualified;

    always_comb begin
        pass      = mask_allows(ctrl.mask, MASK_POL);
        qualified = gin.req && pass && !(ctrl.auto_dis && gin.cpu_rst);
        start     = qualified && armed_q && !sys_rst;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst <= 1'b0;
            left_q  <= '0;
            armed_q <= 1'b1;
        end else begin
            if (start) begin
                sys_rst <= 1'b1;
                left_q  <= LAST;
                armed_q <= 1'b0;
            end else begin
                if (!gin.req) armed_q <= 1'b1;
                if (sys_rst) begin
                    if (left_q == '0) sys_rst <= 1'b0;
                    else              left_q  <= left_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wrg_cause.sv
module wrg_cause (
    input  logic clk,
    input  logic por_rst,
    input  logic set_i,
    input  logic clr_i,
    output logic cause_q
);
    always_ff @(posedge clk) begin
        if (por_rst)    cause_q <= 1'b0;
        else if (set_i) cause_q <= 1'b1;
        else if (clr_i) cause_q <= 1'b0;
    end
endmodule

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate
    import wrg_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4,
    parameter bit          MASK_POL  = 1'b1,
    parameter int unsigned MASK_BIT  = 20,
    parameter int unsigned AUTO_BIT  = 20,
    parameter int unsigned CNT_BIT   = 7,
    parameter int unsigned CAUSE_BIT = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_rst,
    input  logic              wr_en,
    input  logic [WRG_AW-1:0] addr,
    input  logic [WRG_DW-1:0] wdata,
    output logic [WRG_DW-1:0] rdata,
    input  logic              wdt_req_i,
    input  logic              cpu_in_rst_i,
    output logic              sys_rst_o,
    output logic              cnt_en_o
);
    localparam int unsigned PLEN = (PULSE_LEN < 4) ? 4 : PULSE_LEN;

    sel_e     sel;
    ctrl_t    wr_bits;
    ctrl_t    ctrl_q;
    gate_in_t gin;
    logic     start;
    logic     cause_q;
    logic     cause_clr;
    logic     unused_wdata;

    assign sel          = sel_e'(addr);
    assign wr_bits      = '{mask: wdata[MASK_BIT], auto_dis: wdata[AUTO_BIT], cnt_en: wdata[CNT_BIT]};
    assign gin          = '{req: wdt_req_i, cpu_rst: cpu_in_rst_i};
    assign cause_clr    = wr_en && (sel == SEL_STAT) && wdata[CAUSE_BIT];
    assign unused_wdata = ^wdata;

    wrg_regs #(.MASK_POL(MASK_POL)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wr_bits(wr_bits),
        .ctrl_q (ctrl_q)
    );

    wrg_gate #(.PULSE_LEN(PLEN), .MASK_POL(MASK_POL)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .gin    (gin),
        .ctrl   (ctrl_q),
        .sys_rst(sys_rst_o),
        .start  (start)
    );

    wrg_cause u_cause (
        .clk    (clk),
        .por_rst(por_rst),
        .set_i  (start),
        .clr_i  (cause_clr),
        .cause_q(cause_q)
    );

    assign cnt_en_o = ctrl_q.cnt_en;

    always_comb begin
        case (sel)
            SEL_MASK:  rdata = place_bit(ctrl_q.mask, MASK_BIT);
            SEL_AUTO:  rdata = place_bit(ctrl_q.auto_dis, AUTO_BIT);
            SEL_CNTEN: rdata = place_bit(ctrl_q.cnt_en, CNT_BIT);
            default:   rdata = place_bit(cause_q, CAUSE_BIT);
        endcase
    end
endmodule

// File: rtl/wrg_chk.sv
module wrg_chk #(
    parameter int unsigned PULSE_LEN = 4,
    parameter bit          MASK_POL  = 1'b1,
    parameter int unsigned CNT_BIT   = 7,
    parameter int unsigned CAUSE_BIT = 9
) (
    input logic        clk,
    input logic        rst,
    input logic        por_rst,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [31:0] wdata,
    input logic        cpu_in_rst_i,
    input logic        sys_rst_o,
    input logic        cnt_en_o,
    input logic        mask_q,
    input logic        auto_q,
    input logic        cause_q
);
    localparam int unsigned CW = $clog2(PULSE_LEN + 2);
    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)            hi_cnt <= '0;
        else if (sys_rst_o) hi_cnt <= hi_cnt + 1'b1;
        else                hi_cnt <= '0;
    end

    // R2
    mask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_o && (mask_q == MASK_POL)) |=> !sys_rst_o);

    // R3
    auto_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_o && auto_q && cpu_in_rst_i) |=> !sys_rst_o);

    // R4
    cnt_en_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd2) |=> (cnt_en_o == $past(wdata[CNT_BIT])));

    // R5
    pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (hi_cnt < CW'(PULSE_LEN)));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_o) |-> (hi_cnt == CW'(PULSE_LEN)));

    // R7
    cause_set_chk: assert property (@(posedge clk) disable iff (rst || por_rst)
        $rose(sys_rst_o) |-> cause_q);

    // R8
    cause_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        (cause_q && !(wr_en && addr == 2'd3 && wdata[CAUSE_BIT])) |=> cause_q);
endmodule

bind wdt_rst_gate wrg_chk #(
    .PULSE_LEN(PLEN),
    .MASK_POL (MASK_POL),
    .CNT_BIT  (CNT_BIT),
    .CAUSE_BIT(CAUSE_BIT)
) u_wrg_chk (
    .clk         (clk),
    .rst         (rst),
    .por_rst     (por_rst),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .cpu_in_rst_i(cpu_in_rst_i),
    .sys_rst_o   (sys_rst_o),
    .cnt_en_o    (cnt_en_o),
    .mask_q      (ctrl_q.mask),
    .auto_q      (ctrl_q.auto_dis),
    .cause_q     (cause_q)
);

// File: tb/test_wdt_rst_gate.sv
`timescale 1ns/1ps
module test_wdt_rst_gate;
    localparam int L = 4;
    localparam logic [31:0] MB = 32'h0010_0000;
    localparam logic [31:0] AB = 32'h0010_0000;
    localparam logic [31:0] CB = 32'h0000_0080;
    localparam logic [31:0] SB = 32'h0000_0200;

    logic clk = 0;
    logic rst = 1, por_rst = 1, wr_en = 0, req = 0, req2 = 0, cpu = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata, rdata2;
    logic sys_rst, sys_rst2, cnt_en, cnt_en2;
    int n_tests = 0, n_fail = 0;

    always #4 clk = ~clk;

    wdt_rst_gate i_wdt_rst_gate (
        .clk(clk), .rst(rst), .por_rst(por_rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .wdt_req_i(req), .cpu_in_rst_i(cpu),
        .sys_rst_o(sys_rst), .cnt_en_o(cnt_en));

    wdt_rst_gate #(.MASK_POL(1'b0)) i_wdt_rst_gate_inv (
        .clk(clk), .rst(rst), .por_rst(por_rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata2), .wdt_req_i(req2), .cpu_in_rst_i(cpu),
        .sys_rst_o(sys_rst2), .cnt_en_o(cnt_en2));

    // {mask_word_bit, auto_bit, cpu_in_rst, expect_pulse}
    localparam logic [3:0] VEC [7] = '{
        4'b1000, 4'b0001, 4'b0110, 4'b0101, 4'b0011, 4'b1110, 4'b1010
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(posedge clk); @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    // drive one-cycle request on main DUT, return number of high samples
    task automatic fire(output int highs, output logic first);
        req = 1;
        @(posedge clk); @(negedge clk);
        first = sys_rst; req = 0;
        highs = sys_rst ? 1 : 0;
        for (int i = 0; i < L + 2; i++) begin
            @(negedge clk);
            if (sys_rst) highs++;
        end
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++; n_tests++;
        $display("FAIL watchdog timeout");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] r;
        int h, rises;
        logic f, prev;
        repeat (3) @(negedge clk);
        rst = 0; por_rst = 0;
        @(negedge clk);

        // R1 reset state
        check(sys_rst == 0 && cnt_en == 0, "R1 outputs", {sys_rst, cnt_en}, 0);
        rd(0, r); check(r == MB, "R1 mask", r, MB);
        addr = 0; #1; check(rdata2 == 0, "R1 mask inv", rdata2, 0);
        rd(1, r); check(r == AB, "R1 auto", r, AB);
        rd(2, r); check(r == 0, "R1 cnten", r, 0);
        rd(3, r); check(r == 0, "R1 status", r, 0);

        // R2 inverted polarity: blocked at reset, passes once bit set
        req2 = 1; @(posedge clk); @(negedge clk); req2 = 0;
        check(sys_rst2 == 0, "R2 inv blocked", sys_rst2, 0);
        @(negedge clk);
        wr(0, MB);
        req2 = 1; @(posedge clk); @(negedge clk); req2 = 0;
        check(sys_rst2 == 1, "R2 inv pass", sys_rst2, 1);
        repeat (L + 2) @(negedge clk);

        // R2 R3 R5 R7 vector table on main DUT
        foreach (VEC[i]) begin
            wr(0, VEC[i][3] ? MB : 0);
            wr(1, VEC[i][2] ? AB : 0);
            cpu = VEC[i][1];
            fire(h, f);
            check(f == VEC[i][0], $sformatf("R2/R3 vec%0d start", i), f, VEC[i][0]);
            check(h == (VEC[i][0] ? L : 0), $sformatf("R5 vec%0d length", i), h, VEC[i][0] ? L : 0);
            rd(3, r);
            check(r == (VEC[i][0] ? SB : 0), $sformatf("R7 vec%0d cause", i), r, VEC[i][0] ? SB : 0);
            wr(3, SB);
            cpu = 0;
        end

        // R6 held request gives one pulse
        wr(0, 0); wr(1, 0);
        req = 1; rises = 0; prev = 0;
        for (int i = 0; i < 3 * L + 4; i++) begin
            @(negedge clk);
            if (sys_rst && !prev) rises++;
            prev = sys_rst;
        end
        check(rises == 1, "R6 single pulse", rises, 1);
        req = 0; @(negedge clk);
        fire(h, f);
        check(f == 1, "R6 re-arm", f, 1);

        // R8 cause survives rst and write 0
        rst = 1; repeat (2) @(negedge clk); rst = 0;
        rd(3, r); check(r == SB, "R8 survives rst", r, SB);
        wr(3, ~SB); rd(3, r); check(r == SB, "R8 write0", r, SB);
        wr(3, SB); rd(3, r); check(r == 0, "R8 w1c", r, 0);
        wr(0, 0); wr(1, 0);
        fire(h, f);
        por_rst = 1; @(negedge clk); por_rst = 0;
        rd(3, r); check(r == 0, "R8 por clears", r, 0);

        // R4 R9 counter enable
        wr(2, CB); check(cnt_en == 1, "R4 enable", cnt_en, 1);
        wr(2, 32'hFFFF_FFFF); rd(2, r); check(r == CB, "R9 only bit", r, CB);
        wr(2, ~CB); check(cnt_en == 0, "R4 disable", cnt_en, 0);
        rd(2, r); check(r == 0, "R9 other bits", r, 0);
        wr(0, ~MB); rd(0, r); check(r == 0, "R9 mask others", r, 0);

        // R10 set wins over same-edge clear
        req = 1; addr = 3; wdata = SB; wr_en = 1;
        @(posedge clk); @(negedge clk);
        req = 0; wr_en = 0; wdata = 0;
        rd(3, r); check(r == SB, "R10 set priority", r, SB);

        repeat (L + 2) @(negedge clk);
        summary();
        $finish;
    end
endmodule